// File: doc/BRIEF.md
# Dual-Line SPI Master Shift Engine

This block is the shifting core of an SPI master whose two serial data pins have no fixed role. Configuration marks each pin as a driver or a listener. In two-line operation one word leaves on the driving pin while another arrives on the listening pin, one bit in for each bit out. In one-line operation a single selected pin carries the traffic, and a per-transfer direction bit picks whether the master sends or listens (half duplex).

The master derives its serial clock from the system clock through a programmable divider and uses mode 0: the clock idles low, data is sampled on the rising edge and changes on the falling edge, most significant bit first. An active-low chip enable can be switched on by configuration. It leads the first clock edge by half a serial period and trails the last edge by half a serial period. A parent writes a word, pulses the start input, and collects the received word when the one-cycle done pulse appears. All configuration inputs and the divider are captured when a transfer starts.

Top module: `spi_dual_line_master`

## Requirements
- R1: After reset, cs_no is 1, sclk_o is 0, dat_oe_o is 0, busy_o and done_o are 0, and rx_data_o is 0.
- R2: sclk_o is low whenever no transfer runs. Each serial half period lasts cfg_div_i+1 system clocks. A transfer of DATA_W bits makes exactly DATA_W rising edges. The first rising edge comes one half period after the start is accepted.
- R3: The transmit word is sent MSB first. The first bit is on dat_o from the cycle after the start is accepted, and each later bit appears on a falling sclk_o edge.
- R4: The listening pin is sampled on each rising sclk_o edge, MSB first. The DATA_W samples become rx_data_o at the end of the transfer.
- R5: In two-line mode (cfg_single_i=0), bit p of cfg_pin_tx_i set to 1 makes pin p drive (dat_oe_o[p]=1 while busy). The received word comes from pin 0 if bit 0 is 0, otherwise from pin 1 if bit 1 is 0. If neither pin listens, rx_data_o keeps its value.
- R6: In one-line mode (cfg_single_i=1), only pin cfg_line_i is used. With cfg_hd_tx_i=1 it drives. With cfg_hd_tx_i=0 it is sampled and no pin drives for the whole transfer.
- R7: A one-line transmit transfer leaves rx_data_o unchanged. rx_data_o changes only in the cycle where done_o is 1.
- R8: With cfg_cs_en_i=1, cs_no falls in the cycle after the start is accepted. It rises one half period after the last falling sclk_o edge. With cfg_cs_en_i=0, cs_no stays 1.
- R9: A start pulse that arrives while busy_o is 1 is ignored. Timing, transmitted bits and the result are those of the running transfer.
- R10: done_o is a one-cycle pulse. busy_o falls in the same cycle as done_o rises, which is 2*DATA_W+1 half periods after the start is accepted.
- R11: The configuration inputs, the divider and the transmit word are captured when a start is accepted. Changing them during a transfer has no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| tx_data_i | input | DATA_W | Word to transmit |
| cfg_div_i | input | DIV_W | Half period of the serial clock, in system clocks, minus one |
| cfg_pin_tx_i | input | 2 | Two-line mode: per-pin drive (1) or listen (0) |
| cfg_single_i | input | 1 | 1 selects one-line half-duplex mode |
| cfg_line_i | input | 1 | Pin used in one-line mode |
| cfg_hd_tx_i | input | 1 | One-line mode: 1 transmit, 0 receive |
| cfg_cs_en_i | input | 1 | Enables the chip enable output |
| dat_i | input | 2 | Pad input value of each data pin |
| sclk_o | output | 1 | Serial clock |
| cs_no | output | 1 | Active-low chip enable |
| dat_o | output | 2 | Pad output value of each data pin |
| dat_oe_o | output | 2 | Pad output enable of each data pin |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| rx_data_o | output | DATA_W | Last received word |

## Verification
The bench builds the block with DATA_W=8 and DIV_W=4, so the largest divider setting of 15 is within reach. A transfer at that setting runs 17 half periods of 16 system clocks each, which keeps the slowest case short. The fastest setting, a divider of 0, puts a clock edge on every system clock and exercises the tightest edge spacing. Byte-wide words make each routing case quick: both two-line pin assignments, the case where neither pin listens, both one-line directions on either pin, a start that arrives mid-transfer, and a configuration change mid-transfer.

// File: rtl/spi_dl_pkg.sv
package spi_dl_pkg;
  localparam int LINES   = 2;
  localparam int LINE_IW = $clog2(LINES);

  typedef struct packed {
    logic               single;
    logic [LINE_IW-1:0] line;
    logic               hd_tx;
    logic               cs_en;
    logic [LINES-1:0]   pin_tx;
  } line_cfg_t;
endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              shift_i,
  input  logic              sample_i,
  input  logic              bit_i,
  output logic              bit_o,
  output logic [DATA_W-1:0] word_o
);
  logic [DATA_W-1:0] tx_sh_q, rx_sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh_q <= '0;
      rx_sh_q <= '0;
    end else if (load_i) begin
      tx_sh_q <= load_data_i;
      rx_sh_q <= '0;
    end else begin
      if (shift_i)  tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
      if (sample_i) rx_sh_q <= {rx_sh_q[DATA_W-2:0], bit_i};
    end
  end

  assign bit_o  = tx_sh_q[DATA_W-1];
  assign word_o = rx_sh_q;
endmodule

// File: rtl/spi_line_route.sv
module spi_line_route
  import spi_dl_pkg::*;
(
  input  line_cfg_t        cfg_i,
  input  logic             active_i,
  input  logic [LINES-1:0] dat_i,
  output logic [LINES-1:0] oe_o,
  output logic             rx_bit_o,
  output logic             rx_ok_o
);
  logic [LINES-1:0]   drive;
  logic [LINE_IW-1:0] sel;

  for (genvar g = 0; g < LINES; g++) begin : g_pin
    assign drive[g] = cfg_i.single ? (cfg_i.hd_tx && (int'(cfg_i.line) == g))
                                   : cfg_i.pin_tx[g];
    assign oe_o[g]  = active_i & drive[g];
  end

  // lowest-index listening pin wins in two-line mode
  always_comb begin
    sel     = '0;
    rx_ok_o = 1'b0;
    if (cfg_i.single) begin
      sel     = cfg_i.line;
      rx_ok_o = ~cfg_i.hd_tx;
    end else begin
      for (int i = LINES - 1; i >= 0; i--) begin
        if (!cfg_i.pin_tx[i]) begin
          sel     = LINE_IW'(i);
          rx_ok_o = 1'b1;
        end
      end
    end
  end

  assign rx_bit_o = dat_i[sel];
endmodule

// File: rtl/spi_dual_line_master.sv
module spi_dual_line_master
  import spi_dl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic [DIV_W-1:0]  cfg_div_i,
  input  logic [1:0]        cfg_pin_tx_i,
  input  logic              cfg_single_i,
  input  logic              cfg_line_i,
  input  logic              cfg_hd_tx_i,
  input  logic              cfg_cs_en_i,
  input  logic [1:0]        dat_i,
  output logic              sclk_o,
  output logic              cs_no,
  output logic [1:0]        dat_o,
  output logic [1:0]        dat_oe_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_data_o
);
  localparam int PH_LAST = 2 * DATA_W;
  localparam int PH_W    = $clog2(PH_LAST + 2);

  line_cfg_t         cfg_in, cfg_q;
  logic [DIV_W-1:0]  div_q;
  logic [PH_W-1:0]   ph_q;
  logic              busy_q, sclk_q, cs_nq, done_q;
  logic [DATA_W-1:0] rx_q, rx_word;
  logic              tick, launch, last, rise, fall;
  logic              tx_bit, rx_bit, rx_ok;

  assign cfg_in = '{single: cfg_single_i, line: cfg_line_i, hd_tx: cfg_hd_tx_i,
                    cs_en: cfg_cs_en_i, pin_tx: cfg_pin_tx_i};

  assign launch = start_i & ~busy_q;
  assign last   = tick & (ph_q == PH_W'(PH_LAST));
  assign rise   = tick & ~ph_q[0] & ~last;
  assign fall   = tick & ph_q[0];

  spi_tick_gen #(.DIV_W(DIV_W)) i_tick (
    .clk_i, .rst_ni, .run_i(busy_q), .div_i(div_q), .tick_o(tick)
  );

  spi_word_shifter #(.DATA_W(DATA_W)) i_shift (
    .clk_i, .rst_ni, .load_i(launch), .load_data_i(tx_data_i),
    .shift_i(fall), .sample_i(rise), .bit_i(rx_bit),
    .bit_o(tx_bit), .word_o(rx_word)
  );

  spi_line_route i_route (
    .cfg_i(cfg_q), .active_i(busy_q), .dat_i(dat_i),
    .oe_o(dat_oe_o), .rx_bit_o(rx_bit), .rx_ok_o(rx_ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      ph_q   <= '0;
      sclk_q <= 1'b0;
      cs_nq  <= 1'b1;
      done_q <= 1'b0;
      rx_q   <= '0;
      cfg_q  <= '0;
      div_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (launch) begin
        busy_q <= 1'b1;
        ph_q   <= '0;
        sclk_q <= 1'b0;
        cs_nq  <= ~cfg_cs_en_i;
        cfg_q  <= cfg_in;
        div_q  <= cfg_div_i;
      end else if (tick) begin
        ph_q <= ph_q + PH_W'(1);
        if (rise) sclk_q <= 1'b1;
        if (fall) sclk_q <= 1'b0;
        if (last) begin
          busy_q <= 1'b0;
          cs_nq  <= 1'b1;
          done_q <= 1'b1;
          if (rx_ok) rx_q <= rx_word;
        end
      end
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : g_dout
    assign dat_o[g] = tx_bit;
  end

  assign sclk_o    = sclk_q;
  assign cs_no     = cs_nq;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rx_data_o = rx_q;

  assert_sclk_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sclk_o);
  assert_cs_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o || !cfg_q.cs_en) |-> cs_no);
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_busy_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && !tick) |=> (busy_q && $stable(ph_q)));
  assert_single_oe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cfg_q.single) |-> ($countones(dat_oe_o) <= 1));
  assert_hd_rx_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cfg_q.single && !cfg_q.hd_tx) |-> (dat_oe_o == '0));
  assert_rx_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_data_o) |-> done_o);
  assert_cfg_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> ($stable(cfg_q) && $stable(div_q)));
endmodule

// File: tb/test_spi_dual_line_master.sv
`timescale 1ns/1ps
module test_spi_dual_line_master;
  localparam int W  = 8;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [W-1:0]  tx_data_i = '0;
  logic [DW-1:0] cfg_div_i = '0;
  logic [1:0]    cfg_pin_tx_i = 2'b01;
  logic          cfg_single_i = 1'b0, cfg_line_i = 1'b0, cfg_hd_tx_i = 1'b0, cfg_cs_en_i = 1'b1;
  logic [1:0]    dat_i;
  logic          sclk_o, cs_no, busy_o, done_o;
  logic [1:0]    dat_o, dat_oe_o;
  logic [W-1:0]  rx_data_o;

  int total = 0, bad = 0;

  always #2 clk = ~clk;

  spi_dual_line_master #(.DATA_W(W), .DIV_W(DW)) i_spi_dual_line_master (
    .clk_i(clk), .rst_ni, .start_i, .tx_data_i, .cfg_div_i, .cfg_pin_tx_i,
    .cfg_single_i, .cfg_line_i, .cfg_hd_tx_i, .cfg_cs_en_i, .dat_i,
    .sclk_o, .cs_no, .dat_o, .dat_oe_o, .busy_o, .done_o, .rx_data_o
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference
  logic [W-1:0] slave_w [2];
  bit           m_busy = 0, m_done = 0;
  int           m_n = 0, m_half = 1, m_fall = W;
  logic [W-1:0] m_tx = '0, m_acc = '0, m_rxd = '0;
  bit           m_single, m_line, m_hd, m_cs;
  bit [1:0]     m_ptx;
  int           m_rsel;
  bit           m_rok;

  function automatic bit drives(int p);
    if (m_single) return m_hd && (int'(m_line) == p);
    return m_ptx[p];
  endfunction

  always_comb begin
    for (int p = 0; p < 2; p++)
      dat_i[p] = (m_fall < W) ? slave_w[p][W-1-m_fall] : 1'b0;
  end

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_busy = 0; m_done = 0; m_n = 0; m_rxd = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_n++;
        if (m_n % m_half == 0) begin
          int k;
          k = m_n / m_half;
          if (k % 2 == 1 && k < 2*W+1) m_acc = {m_acc[W-2:0], dat_i[m_rsel]};
          if (k % 2 == 0 && k <= 2*W) m_fall++;
          if (k == 2*W+1) begin
            m_busy = 0; m_done = 1;
            if (m_rok) m_rxd = m_acc;
          end
        end
      end else if (start_i) begin
        m_busy = 1; m_n = 0; m_fall = 0; m_acc = '0;
        m_tx = tx_data_i; m_half = int'(cfg_div_i) + 1;
        m_single = cfg_single_i; m_line = cfg_line_i; m_hd = cfg_hd_tx_i;
        m_cs = cfg_cs_en_i; m_ptx = cfg_pin_tx_i;
        if (m_single) begin m_rsel = int'(m_line); m_rok = !m_hd; end
        else if (!m_ptx[0]) begin m_rsel = 0; m_rok = 1; end
        else if (!m_ptx[1]) begin m_rsel = 1; m_rok = 1; end
        else begin m_rsel = 0; m_rok = 0; end
      end
    end
  end

  int rises = 0;
  bit prev_sclk = 0;

  always @(negedge clk) begin
    if (rst_ni) begin
      int kk, fl;
      bit exp_bit;
      kk = m_busy ? m_n / m_half : 0;
      fl = kk / 2;
      exp_bit = (fl < W) ? m_tx[W-1-fl] : 1'b0;
      chk(sclk_o == (m_busy && (kk % 2 == 1)), "R2", "sclk_o", sclk_o, m_busy && (kk % 2 == 1));
      chk(cs_no == !(m_busy && m_cs), "R8", "cs_no", cs_no, !(m_busy && m_cs));
      chk(busy_o == m_busy, "R9", "busy_o", busy_o, m_busy);
      chk(done_o == m_done, "R10", "done_o", done_o, m_done);
      chk(rx_data_o == m_rxd, "R4", "rx_data_o", rx_data_o, m_rxd);
      for (int p = 0; p < 2; p++) begin
        bit oe_e;
        oe_e = m_busy && drives(p);
        chk(dat_oe_o[p] == oe_e, "R5/R6", "dat_oe_o", dat_oe_o[p], oe_e);
        if (oe_e) chk(dat_o[p] == exp_bit, "R3", "dat_o", dat_o[p], exp_bit);
      end
      if (sclk_o && !prev_sclk) rises++;
      prev_sclk = sclk_o;
    end
  end

  logic [W-1:0] last_rx = '0;

  task automatic xfer(input bit single, input bit line, input bit hd, input bit [1:0] ptx,
                      input bit cs, input int div, input logic [W-1:0] tx,
                      input logic [W-1:0] s0, input logic [W-1:0] s1,
                      input bit disturb, input string tag);
    int guard;
    logic [W-1:0] exp;
    @(negedge clk);
    cfg_single_i = single; cfg_line_i = line; cfg_hd_tx_i = hd; cfg_pin_tx_i = ptx;
    cfg_cs_en_i = cs; cfg_div_i = DW'(div); tx_data_i = tx;
    slave_w[0] = s0; slave_w[1] = s1;
    rises = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (disturb) begin
      repeat (5) @(negedge clk);
      start_i = 1'b1; tx_data_i = ~tx; cfg_pin_tx_i = ~ptx; cfg_cs_en_i = ~cs;
      cfg_div_i = DW'(div + 3); cfg_single_i = ~single; cfg_hd_tx_i = ~hd;
      @(negedge clk);
      start_i = 1'b0;
    end
    guard = 0;
    while (!done_o && guard < 5000) begin @(negedge clk); guard++; end
    chk(guard < 5000, tag, "done reached", guard, 0);
    if (single) exp = hd ? last_rx : (line ? s1 : s0);
    else if (!ptx[0]) exp = s0;
    else if (!ptx[1]) exp = s1;
    else exp = last_rx;
    chk(rx_data_o == exp, tag, "received word", rx_data_o, exp);
    chk(rises == W, "R2", "rising edge count", rises, W);
    chk(busy_o == 1'b0, "R10", "busy at done", busy_o, 0);
    last_rx = rx_data_o;
    @(negedge clk);
    chk(done_o == 1'b0, "R10", "done width", done_o, 0);
  endtask

  initial begin
    slave_w[0] = '0; slave_w[1] = '0;
    repeat (3) @(negedge clk);
    chk(cs_no == 1'b1 && sclk_o == 1'b0 && dat_oe_o == 2'b00, "R1", "idle pins",
        {cs_no, sclk_o, dat_oe_o}, 4'b1000);
    chk(busy_o == 1'b0 && done_o == 1'b0 && rx_data_o == '0, "R1", "idle status",
        {busy_o, done_o, rx_data_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    // R5: pin 0 drives, pin 1 listens, fastest clock
    xfer(0, 0, 0, 2'b01, 1, 0,  8'hA5, 8'h00, 8'h3C, 0, "R5");
    // R4 R5: swapped roles, slower clock
    xfer(0, 0, 0, 2'b10, 1, 2,  8'h81, 8'hC3, 8'h00, 0, "R4");
    // R5: neither pin listens, word held
    xfer(0, 0, 0, 2'b11, 1, 1,  8'h5A, 8'h77, 8'h99, 0, "R5");
    // R5: both listen, pin 0 wins
    xfer(0, 0, 0, 2'b00, 1, 0,  8'hFF, 8'h96, 8'h69, 0, "R5");
    // R6 R7: one-line transmit on pin 0, word held
    xfer(1, 0, 1, 2'b00, 1, 1,  8'h3E, 8'h12, 8'h34, 0, "R7");
    // R6: one-line receive on pin 1
    xfer(1, 1, 0, 2'b11, 1, 0,  8'h00, 8'hEE, 8'hB7, 0, "R6");
    // R6: one-line transmit on pin 1
    xfer(1, 1, 1, 2'b00, 1, 0,  8'hC9, 8'h00, 8'h00, 0, "R6");
    // R8: enable disabled, largest divider
    xfer(0, 0, 0, 2'b01, 0, 15, 8'h4D, 8'h00, 8'hD2, 0, "R8");
    // R9 R11: start and config changes during a transfer
    xfer(0, 0, 0, 2'b10, 1, 1,  8'h1F, 8'hE1, 8'h00, 1, "R9");
    xfer(1, 0, 0, 2'b11, 0, 0,  8'h70, 8'h5B, 8'h00, 1, "R11");
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule